// File: doc/BRIEF.md
# Oscillator Calibration Sequence Controller

This block steps through one calibration pass of a slow and a fast on-chip RC oscillator against a crystal reference. It first claims a hardware semaphore that guards a shared period-measurement counter. It brings up the counter clock, selects which RC oscillator drives the counter's reference input and loads how many reference periods to count. It then clears and starts each measurement, waits for the done event and passes every result, tagged with its phase, to the downstream trim-arithmetic units.

A pass has three possible measurements. The slow-oscillator measurement counts 32 periods. The first fast-oscillator measurement counts one period. A second fast measurement runs only when the first result falls outside a small tolerance window. Each clock hand-off uses a four-phase request/acknowledge handshake. Every handshake wait is guarded by a programmable timeout. When the pass ends, or a timeout hits, both clock requests are dropped, all events are masked and the semaphore is released.

Top module: `osc_cal_seq`

## Requirements
- R1: A start request that arrives while `busy` is high is ignored: the running pass completes once, with exactly one semaphore release and no extra measurements.
- R2: A start request with both `lf_en` and `hf_en` low does nothing: `busy` stays low and no semaphore take is attempted.
- R3: On acceptance the block pulses `smph_take`. If `smph_grant` is high in that cycle it proceeds without pulsing `smph_autotake_arm`. Otherwise it pulses `smph_autotake_arm`, sets `evt_mask` to 2'b01 (bit 0 = auto-take-done event) and waits for `smph_autotake_done`.
- R4: The reference select `ref_sel` changes only while `ref_clk_req` and `ref_clk_ack` are both low. `ref_clk_req` is raised only after `cnt_clk_ack` has gone high.
- R5: The slow-oscillator measurement runs with `ref_sel`=1 and `period_count`=32. Each fast-oscillator measurement runs with `ref_sel`=0 and `period_count`=1.
- R6: Every `meas_run` pulse follows a `meas_clear` pulse in the cycle before it. While a measurement runs, `evt_mask` is 2'b10 (bit 1 = measurement-done event).
- R7: A first fast result from 1535 to 1537 inclusive ends the pass. Any other value starts a second fast measurement.
- R8: With `lf_en` low the slow measurement is skipped. With `hf_en` low the pass ends right after the slow measurement.
- R9: At the end of a pass both clock requests go low and the block waits for both acknowledges to go low. It then pulses `smph_release` with `evt_mask`=0, and `busy` falls.
- R10: If a handshake or done wait lasts `timeout_limit` cycles (0 disables the timeout), `timeout_err` is set and the block goes to cleanup. `timeout_err` clears when the next pass is accepted.
- R11: Each measurement result appears on `res_data` with a one-cycle `res_valid` pulse. `res_tag` is 1 for the slow measurement, 2 for the first fast measurement and 3 for the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request one calibration pass |
| lf_en | input | 1 | Enable the slow-oscillator measurement |
| hf_en | input | 1 | Enable the fast-oscillator measurements |
| smph_grant | input | 1 | Semaphore taken in the cycle `smph_take` is high |
| smph_autotake_done | input | 1 | Auto-take completion event |
| cnt_clk_ack | input | 1 | Counter clock acknowledge |
| ref_clk_ack | input | 1 | Reference clock acknowledge |
| meas_done | input | 1 | Measurement done event |
| meas_result | input | 24 | Measured count |
| timeout_limit | input | 16 | Wait timeout in cycles, 0 = off |
| busy | output | 1 | Pass in progress |
| smph_take | output | 1 | Direct semaphore take attempt |
| smph_autotake_arm | output | 1 | Arm semaphore auto-take |
| smph_release | output | 1 | Release the semaphore |
| cnt_clk_req | output | 1 | Counter clock request |
| ref_clk_req | output | 1 | Reference clock request |
| ref_sel | output | 1 | Reference source: 1 slow RC, 0 fast RC |
| period_count | output | 8 | Reference periods to count |
| meas_clear | output | 1 | Clear result and pending done flag |
| meas_run | output | 1 | Start measurement |
| evt_mask | output | 2 | Unmasked events: bit0 auto-take, bit1 done |
| res_valid | output | 1 | Result strobe |
| res_tag | output | 2 | Phase of the result |
| res_data | output | 24 | Result value |
| timeout_err | output | 1 | Last pass aborted on timeout |

## Verification
Passes are driven with both phases enabled, with only the slow phase and with only the fast phase, and with an immediate and a deferred semaphore grant. Together these separate the phase ordering from the skip rules and the direct-take path from the auto-take path. First fast results of 1534, 1535, 1537 and 1538 probe both edges of the tolerance window, which tells an off-by-one comparison apart from a correct one. A stalled reference acknowledge shows that the timeout path still reaches cleanup, and a second start inside a busy pass shows that the request is dropped.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_TAKE, ST_WAIT_SMPH, ST_CNT_ON, ST_REF_OFF, ST_REF_ON,
        ST_ARM, ST_RUN, ST_WAIT_DONE, ST_CLEAN, ST_RELEASE
    } cal_state_e;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_LF   = 2'd1,
        PH_HF1  = 2'd2,
        PH_HF2  = 2'd3
    } cal_phase_e;

    localparam int          EVT_W        = 2;
    localparam logic [1:0]  EVT_NONE     = 2'b00;
    localparam logic [1:0]  EVT_AUTOTAKE = 2'b01;
    localparam logic [1:0]  EVT_MEAS     = 2'b10;

    function automatic logic in_window(input logic [31:0] v,
                                       input logic [31:0] lo,
                                       input logic [31:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/osc_cal_tmr.sv
module osc_cal_tmr #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             active,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (active && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = active && (limit != '0) && (cnt_q >= limit);

endmodule

// File: rtl/osc_cal_strobe.sv
module osc_cal_strobe
    import osc_cal_pkg::*;
#(
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  cal_phase_e       tag_in,
    input  logic [RES_W-1:0] data_in,
    output logic             valid,
    output logic [1:0]       tag,
    output logic [RES_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= PH_NONE;
            data  <= '0;
        end else begin
            valid <= fire;
            if (fire) begin
                tag  <= tag_in;
                data <= data_in;
            end
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid) else $error("strobe longer than one cycle"); // R11

    AST_STROBE_TAGGED: assert property (@(posedge clk) disable iff (rst)
        valid |-> tag != PH_NONE) else $error("strobe without phase tag"); // R11

endmodule

// File: rtl/osc_cal_seq.sv
module osc_cal_seq
    import osc_cal_pkg::*;
#(
    parameter int RES_W      = 24,
    parameter int CNT_W      = 8,
    parameter int TMO_W      = 16,
    parameter int LF_PERIODS = 32,
    parameter int HF_PERIODS = 1,
    parameter int WIN_LO     = 1535,
    parameter int WIN_HI     = 1537
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             lf_en,
    input  logic             hf_en,
    input  logic             smph_grant,
    input  logic             smph_autotake_done,
    input  logic             cnt_clk_ack,
    input  logic             ref_clk_ack,
    input  logic             meas_done,
    input  logic [RES_W-1:0] meas_result,
    input  logic [TMO_W-1:0] timeout_limit,
    output logic             busy,
    output logic             smph_take,
    output logic             smph_autotake_arm,
    output logic             smph_release,
    output logic             cnt_clk_req,
    output logic             ref_clk_req,
    output logic             ref_sel,
    output logic [CNT_W-1:0] period_count,
    output logic             meas_clear,
    output logic             meas_run,
    output logic [EVT_W-1:0] evt_mask,
    output logic             res_valid,
    output logic [1:0]       res_tag,
    output logic [RES_W-1:0] res_data,
    output logic             timeout_err
);
    localparam logic [CNT_W-1:0] LF_CNT = CNT_W'(LF_PERIODS);
    localparam logic [CNT_W-1:0] HF_CNT = CNT_W'(HF_PERIODS);
    localparam logic [31:0]      LO32   = 32'(WIN_LO);
    localparam logic [31:0]      HI32   = 32'(WIN_HI);

    cal_state_e st_q, st_d;
    cal_phase_e phase_q;
    logic       lf_q, hf_q;
    logic       cnt_req_q, ref_req_q, sel_q, err_q;
    logic [CNT_W-1:0] per_q;
    logic       wait_act, tmo, fire, hf_ok, quiet;

    assign hf_ok = in_window(32'(meas_result), LO32, HI32);
    assign quiet = !cnt_req_q && !ref_req_q && !cnt_clk_ack && !ref_clk_ack;

    // cycles spent waiting on an external condition
    always_comb begin
        unique case (st_q)
            ST_CNT_ON:    wait_act = !cnt_clk_ack;
            ST_REF_OFF:   wait_act = ref_clk_ack;
            ST_REF_ON:    wait_act = !ref_clk_ack;
            ST_WAIT_DONE: wait_act = !meas_done;
            ST_CLEAN:     wait_act = !quiet;
            default:      wait_act = 1'b0;
        endcase
    end

    osc_cal_tmr #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (st_d != st_q),
        .active  (wait_act),
        .limit   (timeout_limit),
        .expired (tmo)
    );

    always_comb begin
        st_d              = st_q;
        smph_take         = 1'b0;
        smph_autotake_arm = 1'b0;
        smph_release      = 1'b0;
        meas_clear        = 1'b0;
        meas_run          = 1'b0;
        fire              = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_req && (lf_en || hf_en)) st_d = ST_TAKE;
            end
            ST_TAKE: begin
                smph_take = 1'b1;
                if (smph_grant) begin
                    st_d = ST_CNT_ON;
                end else begin
                    smph_autotake_arm = 1'b1;
                    st_d = ST_WAIT_SMPH;
                end
            end
            ST_WAIT_SMPH: begin
                if (smph_autotake_done) st_d = ST_CNT_ON;
            end
            ST_CNT_ON: begin
                if (cnt_clk_ack) st_d = ST_REF_OFF;
                else if (tmo)    st_d = ST_CLEAN;
            end
            ST_REF_OFF: begin
                if (!ref_clk_ack) st_d = ST_REF_ON;
                else if (tmo)     st_d = ST_CLEAN;
            end
            ST_REF_ON: begin
                if (ref_clk_ack) st_d = ST_ARM;
                else if (tmo)    st_d = ST_CLEAN;
            end
            ST_ARM: begin
                meas_clear = 1'b1;
                st_d = ST_RUN;
            end
            ST_RUN: begin
                meas_run = 1'b1;
                st_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (meas_done) begin
                    fire = 1'b1;
                    unique case (phase_q)
                        PH_LF:   st_d = hf_q  ? ST_REF_OFF : ST_CLEAN;
                        PH_HF1:  st_d = hf_ok ? ST_CLEAN   : ST_REF_OFF;
                        default: st_d = ST_CLEAN;
                    endcase
                end else if (tmo) begin
                    st_d = ST_CLEAN;
                end
            end
            ST_CLEAN: begin
                if (quiet || tmo) st_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                smph_release = 1'b1;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            phase_q   <= PH_NONE;
            lf_q      <= 1'b0;
            hf_q      <= 1'b0;
            cnt_req_q <= 1'b0;
            ref_req_q <= 1'b0;
            sel_q     <= 1'b0;
            per_q     <= '0;
            err_q     <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && st_d == ST_TAKE) begin
                lf_q  <= lf_en;
                hf_q  <= hf_en;
                err_q <= 1'b0;
            end
            if ((st_q == ST_TAKE && smph_grant) ||
                (st_q == ST_WAIT_SMPH && smph_autotake_done)) begin
                cnt_req_q <= 1'b1;
            end
            if (st_q == ST_CNT_ON && cnt_clk_ack) begin
                phase_q <= lf_q ? PH_LF : PH_HF1;
            end
            if (st_q == ST_REF_OFF && !ref_clk_ack) begin
                sel_q     <= (phase_q == PH_LF);
                ref_req_q <= 1'b1;
            end
            if (st_q == ST_ARM) begin
                per_q <= (phase_q == PH_LF) ? LF_CNT : HF_CNT;
            end
            if (st_q == ST_WAIT_DONE && meas_done && st_d == ST_REF_OFF) begin
                phase_q   <= (phase_q == PH_LF) ? PH_HF1 : PH_HF2;
                ref_req_q <= 1'b0;
            end
            if (tmo) begin
                err_q <= 1'b1;
            end
            if (st_q == ST_CLEAN) begin
                cnt_req_q <= 1'b0;
                ref_req_q <= 1'b0;
            end
            if (st_q == ST_RELEASE) begin
                phase_q <= PH_NONE;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_WAIT_SMPH:          evt_mask = EVT_AUTOTAKE;
            ST_RUN, ST_WAIT_DONE:  evt_mask = EVT_MEAS;
            default:               evt_mask = EVT_NONE;
        endcase
    end

    assign busy         = (st_q != ST_IDLE);
    assign cnt_clk_req  = cnt_req_q;
    assign ref_clk_req  = ref_req_q;
    assign ref_sel      = sel_q;
    assign period_count = per_q;
    assign timeout_err  = err_q;

    osc_cal_strobe #(.RES_W(RES_W)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .tag_in  (phase_q),
        .data_in (meas_result),
        .valid   (res_valid),
        .tag     (res_tag),
        .data    (res_data)
    );

    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_req && !lf_en && !hf_en) |=> !busy)
        else $error("pass accepted with both phases disabled"); // R2

    AST_ARM_ONLY_UNGRANTED: assert property (@(posedge clk) disable iff (rst)
        smph_autotake_arm |-> !smph_grant)
        else $error("auto-take armed despite grant"); // R3

    AST_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ref_sel != $past(ref_sel)) |-> (!$past(ref_clk_req) && !$past(ref_clk_ack)))
        else $error("reference switched during handshake"); // R4

    AST_REF_AFTER_CNT: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_clk_req) |-> cnt_clk_req)
        else $error("reference requested without counter clock"); // R4

    AST_CLEAR_BEFORE_RUN: assert property (@(posedge clk) disable iff (rst)
        meas_run |-> $past(meas_clear))
        else $error("run without prior clear"); // R6

    AST_RUN_PERIODS: assert property (@(posedge clk) disable iff (rst)
        meas_run |-> (ref_sel ? (period_count == LF_CNT) : (period_count == HF_CNT)))
        else $error("period count does not match reference"); // R5

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        smph_release |-> (!cnt_clk_req && !ref_clk_req && evt_mask == EVT_NONE))
        else $error("release with a clock request still up"); // R9

    AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (rst)
        smph_release |=> !busy)
        else $error("busy held after release"); // R9

endmodule

// File: tb/osc_cal_seq_test.sv
module osc_cal_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0, lf_en = 1'b0, hf_en = 1'b0, smph_grant = 1'b1;
    logic        smph_autotake_done = 1'b0, cnt_clk_ack = 1'b0, ref_clk_ack = 1'b0;
    logic        meas_done = 1'b0;
    logic [23:0] meas_result = '0;
    logic [15:0] timeout_limit = 16'd40;
    logic        busy, smph_take, smph_autotake_arm, smph_release;
    logic        cnt_clk_req, ref_clk_req, ref_sel, meas_clear, meas_run;
    logic [7:0]  period_count;
    logic [1:0]  evt_mask, res_tag;
    logic        res_valid, timeout_err;
    logic [23:0] res_data;

    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_cal_seq uut (
        .clk(clk), .rst(rst), .start_req(start_req), .lf_en(lf_en), .hf_en(hf_en),
        .smph_grant(smph_grant), .smph_autotake_done(smph_autotake_done),
        .cnt_clk_ack(cnt_clk_ack), .ref_clk_ack(ref_clk_ack), .meas_done(meas_done),
        .meas_result(meas_result), .timeout_limit(timeout_limit), .busy(busy),
        .smph_take(smph_take), .smph_autotake_arm(smph_autotake_arm),
        .smph_release(smph_release), .cnt_clk_req(cnt_clk_req), .ref_clk_req(ref_clk_req),
        .ref_sel(ref_sel), .period_count(period_count), .meas_clear(meas_clear),
        .meas_run(meas_run), .evt_mask(evt_mask), .res_valid(res_valid),
        .res_tag(res_tag), .res_data(res_data), .timeout_err(timeout_err)
    );

    // environment model and logs
    logic [1:0] cnt_pipe = '0, ref_pipe = '0;
    bit         ref_stall = 1'b0;
    int         done_dly = 0, at_dly = 0;
    int         res_q [3];
    int         res_base = 0;
    int         n_strobe = 0, n_run = 0, n_arm = 0, n_rel = 0, n_take = 0;
    int         tag_log [64], data_log [64], sel_log [64], per_log [64];
    int         n_mask_bad = 0, n_smph_mask = 0;

    always @(negedge clk) begin
        cnt_pipe    <= {cnt_pipe[0], cnt_clk_req};
        ref_pipe    <= {ref_pipe[0], ref_clk_req};
        cnt_clk_ack <= cnt_pipe[1];
        ref_clk_ack <= ref_stall ? (ref_pipe[1] & ref_clk_ack) : ref_pipe[1];
        if (res_valid) begin
            tag_log[n_strobe % 64]  = int'(res_tag);
            data_log[n_strobe % 64] = int'(res_data);
            n_strobe++;
        end
        if (smph_release) n_rel++;
        if (smph_take) n_take++;
        if (evt_mask == 2'b01) n_smph_mask++;
        if (meas_run) begin
            sel_log[n_run % 64] = int'(ref_sel);
            per_log[n_run % 64] = int'(period_count);
            if (evt_mask != 2'b10) n_mask_bad++;
            done_dly = 3;
        end
        meas_done <= 1'b0;
        if (done_dly > 0) begin
            done_dly--;
            if (done_dly == 0) begin
                meas_done   <= 1'b1;
                meas_result <= 24'(res_q[(n_run - res_base) % 3]);
                n_run++;
            end
        end
        if (smph_autotake_arm) begin
            n_arm++;
            at_dly = 5;
        end
        smph_autotake_done <= 1'b0;
        if (at_dly > 0) begin
            at_dly--;
            if (at_dly == 0) smph_autotake_done <= 1'b1;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_run(bit lf, bit hf, bit grant, int rl, int r1, int r2, bit poke);
        int guard;
        res_q[0] = lf ? rl : r1;
        res_q[1] = lf ? r1 : r2;
        res_q[2] = r2;
        res_base = n_run;
        lf_en = lf; hf_en = hf; smph_grant = grant;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        if (poke) begin
            tick(6);
            start_req = 1'b1;
            tick();
            start_req = 1'b0;
        end
        guard = 0;
        while (busy && guard < 2000) begin
            tick();
            guard++;
        end
        tick(10);
    endtask

    task automatic t_reset;
        chk(!busy, "R9", "busy after reset", int'(busy), 0);
        chk(!cnt_clk_req && !ref_clk_req, "R9", "requests after reset",
            int'({cnt_clk_req, ref_clk_req}), 0);
        chk(evt_mask == 2'b00, "R6", "mask after reset", int'(evt_mask), 0);
        chk(!res_valid && !timeout_err, "R11", "strobe/err after reset",
            int'({res_valid, timeout_err}), 0);
    endtask

    // both phases, direct grant, first fast result perfect
    task automatic t_full_in_window;
        int s0 = n_strobe, r0 = n_run, a0 = n_arm, l0 = n_rel;
        do_run(1, 1, 1, 1000, 1536, 0, 0);
        chk(n_strobe - s0 == 2, "R7", "strobes in-window", n_strobe - s0, 2);
        chk(tag_log[s0 % 64] == 1, "R11", "LF tag", tag_log[s0 % 64], 1);
        chk(data_log[s0 % 64] == 1000, "R11", "LF data", data_log[s0 % 64], 1000);
        chk(tag_log[(s0 + 1) % 64] == 2, "R11", "HF1 tag", tag_log[(s0 + 1) % 64], 2);
        chk(data_log[(s0 + 1) % 64] == 1536, "R11", "HF1 data", data_log[(s0 + 1) % 64], 1536);
        chk(sel_log[r0 % 64] == 1 && per_log[r0 % 64] == 32, "R5", "LF periods",
            per_log[r0 % 64], 32);
        chk(sel_log[(r0 + 1) % 64] == 0 && per_log[(r0 + 1) % 64] == 1, "R5", "HF periods",
            per_log[(r0 + 1) % 64], 1);
        chk(n_arm == a0, "R3", "no auto-take when granted", n_arm - a0, 0);
        chk(n_rel - l0 == 1, "R9", "one release", n_rel - l0, 1);
        chk(!busy && !cnt_clk_req && !ref_clk_req, "R9", "idle after pass",
            int'({busy, cnt_clk_req, ref_clk_req}), 0);
    endtask

    // both phases, first fast result off: second fast run
    task automatic t_full_refine;
        int s0 = n_strobe, r0 = n_run;
        do_run(1, 1, 1, 900, 1600, 1540, 0);
        chk(n_strobe - s0 == 3, "R7", "strobes out-of-window", n_strobe - s0, 3);
        chk(tag_log[(s0 + 2) % 64] == 3, "R11", "HF2 tag", tag_log[(s0 + 2) % 64], 3);
        chk(data_log[(s0 + 2) % 64] == 1540, "R11", "HF2 data", data_log[(s0 + 2) % 64], 1540);
        chk(per_log[(r0 + 2) % 64] == 1 && sel_log[(r0 + 2) % 64] == 0, "R5",
            "HF2 periods", per_log[(r0 + 2) % 64], 1);
        chk(n_mask_bad == 0, "R6", "mask during runs", n_mask_bad, 0);
    endtask

    // slow only, semaphore busy: auto-take path
    task automatic t_lf_only_autotake;
        int s0 = n_strobe, a0 = n_arm, m0 = n_smph_mask, l0 = n_rel;
        do_run(1, 0, 0, 777, 0, 0, 0);
        chk(n_arm - a0 == 1, "R3", "auto-take armed", n_arm - a0, 1);
        chk(n_smph_mask - m0 >= 3, "R3", "auto-take mask cycles", n_smph_mask - m0, 4);
        chk(n_strobe - s0 == 1, "R8", "slow only strobes", n_strobe - s0, 1);
        chk(tag_log[s0 % 64] == 1 && data_log[s0 % 64] == 777, "R8", "slow only tag",
            tag_log[s0 % 64], 1);
        chk(n_rel - l0 == 1, "R9", "release after slow only", n_rel - l0, 1);
    endtask

    // fast only, window edges
    task automatic t_hf_edges;
        int vals [4] = '{1534, 1535, 1537, 1538};
        int exp_n [4] = '{2, 1, 1, 2};
        for (int i = 0; i < 4; i++) begin
            int s0 = n_strobe;
            int r0 = n_run;
            do_run(0, 1, 1, 0, vals[i], 1536, 0);
            chk(n_strobe - s0 == exp_n[i], "R7", $sformatf("strobes for %0d", vals[i]),
                n_strobe - s0, exp_n[i]);
            chk(tag_log[s0 % 64] == 2 && sel_log[r0 % 64] == 0, "R8", "slow skipped",
                tag_log[s0 % 64], 2);
        end
    endtask

    task automatic t_disabled;
        int t0 = n_take;
        int seen = 0;
        lf_en = 1'b0; hf_en = 1'b0;
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (busy) seen++;
            tick();
        end
        chk(seen == 0, "R2", "busy with both disabled", seen, 0);
        chk(n_take == t0, "R2", "take with both disabled", n_take - t0, 0);
    endtask

    task automatic t_start_while_busy;
        int s0 = n_strobe, l0 = n_rel, t0 = n_take;
        do_run(1, 1, 1, 1200, 1536, 0, 1);
        chk(n_strobe - s0 == 2, "R1", "strobes with extra start", n_strobe - s0, 2);
        chk(n_rel - l0 == 1, "R1", "releases with extra start", n_rel - l0, 1);
        chk(n_take - t0 == 1, "R1", "takes with extra start", n_take - t0, 1);
        chk(!busy, "R1", "idle after extra start", int'(busy), 0);
    endtask

    task automatic t_timeout;
        int s0 = n_strobe, l0 = n_rel;
        timeout_limit = 16'd10;
        ref_stall = 1'b1;
        do_run(0, 1, 1, 0, 1536, 0, 0);
        chk(timeout_err, "R10", "error flag", int'(timeout_err), 1);
        chk(n_strobe == s0, "R10", "no result after timeout", n_strobe - s0, 0);
        chk(n_rel - l0 == 1 && !busy, "R10", "cleanup after timeout", n_rel - l0, 1);
        ref_stall = 1'b0;
        timeout_limit = 16'd40;
        tick(5);
        do_run(0, 1, 1, 0, 1536, 0, 0);
        chk(!timeout_err, "R10", "error cleared by new pass", int'(timeout_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_full_in_window();
        t_full_refine();
        t_lf_only_autotake();
        t_hf_edges();
        t_disabled();
        t_start_while_busy();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule